// File: doc/BRIEF.md
# Predicated Vector Load/Store Sequencer

The block transfers one 128-bit vector register to memory, or fills it from memory, one element at a time under a 16-bit per-byte lane mask. A single start pulse latches the operation: the direction, the memory element size, the register element size, signedness, the base address, the lane mask and the current register contents. The sequencer then walks the register's elements in ascending order. Each active element costs one request on a simple single-element memory port. A masked element costs one idle cycle and no bus traffic. The address still advances past a masked element.

The memory element may be narrower than the register element. On a load, the narrow value is sign- or zero-extended into the wider lane. On a store, only the low bytes of the lane are written. Memory is little-endian. Element e occupies register bits [e*ebytes*8 +: ebytes*8]. When the last element has been handled, a one-cycle completion pulse tells the surrounding pipeline that it may advance its predication state. The updated register is valid in the same cycle as that pulse.

Top module: `vec_lane_mover`

## Requirements
- R1: After reset, busy, done and mem_req are all low.
- R2: Size codes are 0 = byte, 1 = half (2 bytes) and 2 = word (4 bytes). An operation visits 16/ebytes elements, in order e = 0, 1, and so on. Element e is active exactly when lane_mask bit e*ebytes is set.
- R3: The request for element e carries address base_addr + e*mbytes and mem_size equal to the memory size code. A masked element still consumes its address slot but issues no request, so the number of requests equals the number of active elements.
- R4: On a load (is_store = 0), each active element receives the low mbytes of mem_rdata. Each inactive element keeps its value from vreg_in.
- R5: On a load with a memory size smaller than the element size, the loaded value is sign-extended when sign_ext = 1 and zero-extended when sign_ext = 0, up to the full element width.
- R6: On a store (is_store = 1), each active element issues mem_we = 1. mem_wdata holds the element's low mbytes in its low bytes, and all higher bits are zero (truncation). An inactive element writes nothing.
- R7: A request, together with its address, direction and write data, stays unchanged until mem_ready is seen high.
- R8: done is high for exactly one cycle, at the edge that completes the last element, and vreg_out holds the final register value in that cycle. busy is low in the following cycle.
- R9: An unsupported combination raises done one cycle after start, issues no request, and returns vreg_out equal to vreg_in. A code is unsupported when it equals 3, or when the memory size is larger than the element size.
- R10: A start pulse that arrives while busy is high has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| is_store | input | 1 | 1 = store, 0 = load |
| mem_sz | input | 2 | Memory element size code |
| elem_sz | input | 2 | Register element size code |
| sign_ext | input | 1 | Sign-extend narrow loads |
| base_addr | input | ADDR_W | Address of element 0 |
| lane_mask | input | NBYTES | Per-byte lane enable |
| vreg_in | input | NBYTES*8 | Register contents at start |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vreg_out | output | NBYTES*8 | Updated register |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request address |
| mem_size | output | 2 | Request size code |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_rdata | input | 32 | Read data, right-aligned |
| mem_ready | input | 1 | Request accepted this cycle |

## Verification
Three kinds of internal fault show up quickly at the ports:
- A wrong element index or byte position shows on the very next request. It either carries an address that is not base plus a multiple of the memory size, or it belongs to an element whose mask bit is clear.
- A wrong address increment shows by the second element, because every masked or unmasked step moves the address.
- A wrong extension, truncation or lane-merge corrupts vreg_out or the memory image. These are compared in full at the completion pulse.

The bench sweeps every size, direction and sign combination against fixed and random masks, with random ready latency.

// File: rtl/vec_lane_mover.sv
module vec_lane_mover #(
  parameter int ADDR_W = 32,
  parameter int NBYTES = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  is_store,
  input  logic [1:0]            mem_sz,
  input  logic [1:0]            elem_sz,
  input  logic                  sign_ext,
  input  logic [ADDR_W-1:0]     base_addr,
  input  logic [NBYTES-1:0]     lane_mask,
  input  logic [NBYTES*8-1:0]   vreg_in,
  output logic                  busy,
  output logic                  done,
  output logic [NBYTES*8-1:0]   vreg_out,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [1:0]            mem_size,
  output logic [31:0]           mem_wdata,
  input  logic [31:0]           mem_rdata,
  input  logic                  mem_ready
);

  localparam int VW = NBYTES * 8;
  localparam int IW = $clog2(NBYTES) + 1;
  localparam int BW = $clog2(NBYTES);

  logic              busy_q, done_q, st_q, sgn_q;
  logic [1:0]        msz_q, esz_q;
  logic [ADDR_W-1:0] addr_q;
  logic [NBYTES-1:0] mask_q;
  logic [VW-1:0]     vreg_q, vreg_nxt;
  logic [IW-1:0]     e_q;

  wire bad_op = (mem_sz == 2'd3) || (elem_sz == 2'd3) || (mem_sz > elem_sz);

  wire [IW-1:0] b_pos  = e_q << esz_q;
  wire [IW-1:0] nxt_b  = (e_q + IW'(1)) << esz_q;
  wire          last   = nxt_b >= IW'(NBYTES);
  wire          act    = mask_q[b_pos[BW-1:0]];
  wire          step   = busy_q && (!act || mem_ready);
  wire          ld_take = busy_q && act && mem_ready && !st_q;

  wire [ADDR_W-1:0] mbytes = ADDR_W'(1) << msz_q;

  wire [VW+31:0] padded = {32'b0, vreg_q} >> {b_pos, 3'b000};
  wire [31:0]    elem   = padded[31:0];

  logic [31:0] wdata, ld_val;

  always_comb begin
    case (msz_q)
      2'd0:    wdata = {24'b0, elem[7:0]};
      2'd1:    wdata = {16'b0, elem[15:0]};
      default: wdata = elem;
    endcase
  end

  always_comb begin
    case (msz_q)
      2'd0:    ld_val = {{24{sgn_q & mem_rdata[7]}}, mem_rdata[7:0]};
      2'd1:    ld_val = {{16{sgn_q & mem_rdata[15]}}, mem_rdata[15:0]};
      default: ld_val = mem_rdata;
    endcase
  end

  wire [1:0] lane_msk = (esz_q == 2'd0) ? 2'b00 : (esz_q == 2'd1) ? 2'b01 : 2'b11;

  always_comb begin
    vreg_nxt = vreg_q;
    for (int j = 0; j < NBYTES; j++) begin
      if (ld_take && ((IW'(j) >> esz_q) == e_q))
        vreg_nxt[j*8 +: 8] = ld_val[{(2'(j) & lane_msk), 3'b000} +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      st_q   <= 1'b0;
      sgn_q  <= 1'b0;
      msz_q  <= 2'd0;
      esz_q  <= 2'd0;
      addr_q <= '0;
      mask_q <= '0;
      vreg_q <= '0;
      e_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          vreg_q <= vreg_in;
          st_q   <= is_store;
          sgn_q  <= sign_ext;
          msz_q  <= mem_sz;
          esz_q  <= elem_sz;
          addr_q <= base_addr;
          mask_q <= lane_mask;
          e_q    <= '0;
          if (bad_op) done_q <= 1'b1;
          else        busy_q <= 1'b1;
        end
      end else begin
        vreg_q <= vreg_nxt;
        if (step) begin
          addr_q <= addr_q + mbytes;
          e_q    <= e_q + IW'(1);
          if (last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign vreg_out  = vreg_q;
  assign mem_req   = busy_q && act;
  assign mem_we    = st_q;
  assign mem_addr  = addr_q;
  assign mem_size  = msz_q;
  assign mem_wdata = wdata;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (!mem_req || mem_ready) && !last) |=>
      (mem_addr == $past(mem_addr) + (ADDR_W'(1) << mem_size)));

  a_r9_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && bad_op) |=> (done && !busy && !mem_req));

  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(step && last)) |=> $stable(mem_size) && $stable(mem_we));

endmodule

// File: tb/vec_lane_mover_tb.sv
module vec_lane_mover_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, is_store = 1'b0, sign_ext = 1'b0;
  logic [1:0] mem_sz = 2'd0, elem_sz = 2'd0;
  logic [31:0] base_addr = '0;
  logic [15:0] lane_mask = '0;
  logic [127:0] vreg_in = '0;
  logic busy, done, mem_req, mem_we;
  logic [127:0] vreg_out;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  int checks = 0, fails = 0;
  int nreq = 0;
  logic [7:0] mem [256];
  logic [7:0] expmem [256];
  logic [31:0] cur_base;
  logic [1:0] cur_ms, cur_es;
  logic [15:0] cur_mask;
  int lat_cnt = 0;

  always #10 clk = ~clk;

  vec_lane_mover u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .mem_sz(mem_sz), .elem_sz(elem_sz), .sign_ext(sign_ext),
    .base_addr(base_addr), .lane_mask(lane_mask), .vreg_in(vreg_in),
    .busy(busy), .done(done), .vreg_out(vreg_out), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: ready after 0..2 idle cycles, held one cycle
  initial begin
    forever begin
      @(negedge clk);
      if (mem_ready) begin
        mem_ready = 1'b0;
        lat_cnt = $urandom % 3;
      end
      if (mem_req) begin
        if (lat_cnt == 0) begin
          logic [31:0] off;
          int idx;
          off = mem_addr - cur_base;
          idx = int'(off >> cur_ms);
          nreq++;
          // R3: aligned slot, active element, right size
          chk((off & ((32'd1 << cur_ms) - 1)) == 0 && idx < (16 >> cur_es) &&
              cur_mask[idx << cur_es] && mem_size == cur_ms,
              "R3/R2 request slot", {96'b0, mem_addr}, {96'b0, cur_base});
          if (mem_we) begin
            // R6: zero above stored bytes
            if (cur_ms != 2'd2)
              chk((mem_wdata >> (8 << cur_ms)) == 0, "R6 truncation", {96'b0, mem_wdata}, 128'b0);
            for (int k = 0; k < (1 << cur_ms); k++)
              mem[(mem_addr[7:0] + k) & 8'hff] = mem_wdata[k*8 +: 8];
          end else begin
            for (int k = 0; k < 4; k++)
              mem_rdata[k*8 +: 8] = mem[(mem_addr[7:0] + k) & 8'hff];
          end
          mem_ready = 1'b1;
        end else lat_cnt--;
      end
    end
  end

  task automatic run_op(input bit st, input logic [1:0] ms, input logic [1:0] es, input bit sg,
                        input logic [31:0] a, input logic [15:0] mk, input logic [127:0] vin,
                        input bit poke);
    logic [127:0] exp;
    int nact, cyc;
    bit seen;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      expmem[i] = mem[i];
    end
    exp = vin;
    nact = 0;
    for (int e = 0; e < (16 >> es); e++) begin
      int b;
      logic [31:0] v;
      b = e << es;
      if (mk[b]) begin
        nact++;
        if (st) begin
          for (int k = 0; k < (1 << ms); k++)
            expmem[(a[7:0] + e * (1 << ms) + k) & 255] = vin[(b + k) * 8 +: 8];
        end else begin
          v = 0;
          for (int k = 0; k < (1 << ms); k++)
            v[k*8 +: 8] = mem[(a[7:0] + e * (1 << ms) + k) & 255];
          if (sg && ms < es && v[(8 << ms) - 1])
            for (int k = (1 << ms); k < 4; k++) v[k*8 +: 8] = 8'hff;
          for (int k = 0; k < (1 << es); k++)
            exp[(b + k) * 8 +: 8] = v[k*8 +: 8];
        end
      end
    end
    cur_base = a; cur_ms = ms; cur_es = es; cur_mask = mk;
    nreq = 0;
    @(negedge clk);
    is_store = st; mem_sz = ms; elem_sz = es; sign_ext = sg;
    base_addr = a; lane_mask = mk; vreg_in = vin; start = 1'b1;
    seen = 0;
    cyc = 0;
    while (!seen && cyc < 200) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (poke && cyc == 1 && busy) begin
        // R10: second start while busy, different operands
        start = 1'b1; is_store = ~st; base_addr = a + 32'h40;
        lane_mask = ~mk; vreg_in = ~vin; mem_sz = 2'd0; elem_sz = 2'd0;
      end
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(seen, "R8 done seen", {127'b0, seen}, 128'd1);
    if (st) begin
      bit same;
      same = 1;
      for (int i = 0; i < 256; i++) if (mem[i] !== expmem[i]) same = 0;
      chk(same, poke ? "R10/R6 store image" : "R6 store image", {127'b0, same}, 128'd1);
    end else begin
      chk(vreg_out === exp, poke ? "R10/R4/R5 load result" : "R4/R5 load result", vreg_out, exp);
    end
    chk(nreq == nact, "R3 request count", 128'(nreq), 128'(nact));
    @(negedge clk);
    chk(!done && !busy, "R8 single pulse", {126'b0, done, busy}, 128'b0);
  endtask

  initial begin
    #40000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] masks [6];
    masks[0] = 16'h0000; masks[1] = 16'hffff; masks[2] = 16'h5555;
    masks[3] = 16'h1111; masks[4] = 16'h00ff; masks[5] = 16'hf00f;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset state", {125'b0, busy, done, mem_req}, 128'b0);
    rst_n = 1'b1;
    for (int st = 0; st < 2; st++)
      for (int ms = 0; ms < 3; ms++)
        for (int es = ms; es < 3; es++)
          for (int sg = 0; sg < 2; sg++)
            for (int m = 0; m < 9; m++) begin
              logic [15:0] mk;
              mk = (m < 6) ? masks[m] : 16'($urandom);
              run_op(st[0], 2'(ms), 2'(es), sg[0], 32'h2000_0000 | ($urandom & 32'h7f), mk,
                     {$urandom, $urandom, $urandom, $urandom}, m == 8);
            end
    // R9: unsupported combinations
    for (int c = 0; c < 4; c++) begin
      logic [127:0] v;
      logic [1:0] ms, es;
      v = {$urandom, $urandom, $urandom, $urandom};
      ms = (c == 0) ? 2'd2 : (c == 1) ? 2'd1 : (c == 2) ? 2'd3 : 2'd0;
      es = (c == 0) ? 2'd1 : (c == 1) ? 2'd0 : (c == 2) ? 2'd3 : 2'd3;
      nreq = 0;
      @(negedge clk);
      is_store = c[0]; mem_sz = ms; elem_sz = es; lane_mask = 16'hffff;
      vreg_in = v; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !busy && !mem_req, "R9 immediate done", {125'b0, done, busy, mem_req}, 128'd4);
      chk(vreg_out === v, "R9 register unchanged", vreg_out, v);
      @(negedge clk);
      chk(nreq == 0 && !done, "R9 no request", 128'(nreq), 128'd0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule